// File: doc/BRIEF.md
# Transmit Credit Link Activation Controller

This controller sits on the core side of a credit-managed transmit channel. An application asks for the channel by raising a request line. The controller answers with an acknowledge once it is ready to take traffic. It then hands out its fixed pool of transmit credits as single-cycle grant pulses. Right after activation the whole pool goes out on consecutive cycles. After that, one credit goes back out each time the internal buffer reports that a slot has drained.

When a link reset is pending, or when the application withdraws its request, the controller stops granting and raises a deactivation hint. It then counts credits coming home, both on the application's return strobe and on buffer drain pulses. Once nothing is outstanding it drops the acknowledge. When the request is also low it goes back to the stopped state. A return strobe that arrives while nothing is outstanding is flagged as an overflow error and has no other effect. Buffer management, packet data and the physical link are outside this block. The free-space and reset-pending inputs stand in for them.

Top module: `credit_link_ctrl`

## Requirements
- R1: After reset the acknowledge, hint, grant and overflow outputs are all low and the controller is stopped with zero credits outstanding.
- R2: With the request high and reset-pending low, the acknowledge rises after the second rising clock edge that sees the request, and it stays high while the link is active.
- R3: The first grant pulse comes in the first cycle the acknowledge is high. Grants follow on exactly CREDITS (default 8) consecutive cycles, and then the grant stays low.
- R4: While active, each cycle in which the free-space input is high releases one credit. The grant pulse appears in the cycle right after the edge that captures the free-space input, so back-to-back free-space cycles give back-to-back grants.
- R5: The outstanding credit count never exceeds CREDITS. With all credits outstanding and no free-space input, no grant is issued.
- R6: Reset-pending seen high while active raises the deactivation hint after the next edge. No grant is issued while the hint is high.
- R7: During deactivation the acknowledge stays high until the outstanding count reaches zero, and it is low from the cycle after the edge that brings the count to zero. The hint stays high until the request is low with zero outstanding, and it drops after the following edge.
- R8: Dropping the request while active also enters deactivation, with the hint raised. Return strobes and free-space pulses taken in the same cycle each take back one credit.
- R9: A return strobe captured while zero credits are outstanding gives a one-cycle overflow pulse in the following cycle and leaves the count at zero.
- R10: While reset-pending is high in the stopped state, a high request does not activate the link. Activation goes ahead once reset-pending falls.
- R11: A free-space pulse with zero credits outstanding is ignored. It raises no overflow, and a later activation still grants exactly CREDITS credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_req | input | 1 | Application asks for an active link; held high while needed |
| reset_pending | input | 1 | A link reset is coming; blocks activation and starts deactivation |
| space_free | input | 1 | One buffer slot drained this cycle; gives back one credit |
| credit_ret | input | 1 | Application returns one credit this cycle |
| act_ack | output | 1 | Core is ready to accept traffic |
| deact_hint | output | 1 | Application should return credits and release the link |
| credit_gnt | output | 1 | One credit granted this cycle |
| overflow_err | output | 1 | Return strobe seen with no credits outstanding |

## Verification
The bench builds the block with the default pool of eight credits. It counts the full initial burst pulse by pulse and drains the pool completely in both deactivation paths: by return strobes alone, and by paired return and free-space pulses. The pool is small enough that both the full-pool case, where grants must stop, and the empty-pool case, where overflow must fire and a free-space pulse must be ignored, are reached within a few dozen cycles of each scenario.

// File: rtl/credit_link_ctrl.sv
module credit_link_ctrl #(
  parameter int CREDITS = 8,
  localparam int CW = $clog2(CREDITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_req,
  input  logic reset_pending,
  input  logic space_free,
  input  logic credit_ret,
  output logic act_ack,
  output logic deact_hint,
  output logic credit_gnt,
  output logic overflow_err
);

  typedef enum logic [1:0] {ST_STOP, ST_ARM, ST_RUN, ST_DRAIN} state_t;

  state_t        state, state_d;
  logic [CW-1:0] outst, outst_d;
  logic          ret_ok, free_ok;

  assign credit_gnt = (state == ST_RUN) && (outst < CW'(CREDITS)) && act_req && !reset_pending;
  assign ret_ok     = credit_ret && (outst != '0);
  assign free_ok    = space_free && (outst != CW'(ret_ok));
  assign outst_d    = outst + CW'(credit_gnt) - CW'(ret_ok) - CW'(free_ok);

  assign act_ack    = (state == ST_RUN) || ((state == ST_DRAIN) && (outst != '0));
  assign deact_hint = (state == ST_DRAIN);

  always_comb begin
    state_d = state;
    case (state)
      ST_STOP:  if (act_req && !reset_pending) state_d = ST_ARM;
      ST_ARM:   state_d = act_req ? ST_RUN : ST_STOP;
      ST_RUN:   if (reset_pending || !act_req) state_d = ST_DRAIN;
      ST_DRAIN: if ((outst == '0) && !act_req) state_d = ST_STOP;
      default:  state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_STOP;
      outst        <= '0;
      overflow_err <= 1'b0;
    end else begin
      state        <= state_d;
      outst        <= outst_d;
      overflow_err <= credit_ret && (outst == '0);
    end
  end

endmodule

// File: rtl/credit_link_ctrl_chk.sv
module credit_link_ctrl_chk #(
  parameter int CREDITS = 8,
  localparam int CW = $clog2(CREDITS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_ack,
  input logic          deact_hint,
  input logic          credit_gnt,
  input logic          credit_ret,
  input logic          space_free,
  input logic          overflow_err,
  input logic [CW-1:0] outst
);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= CW'(CREDITS));

  a_r6_no_grant_in_hint: assert property (@(posedge clk) disable iff (!rst_n)
    deact_hint |-> !credit_gnt);

  a_r3_grant_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    credit_gnt |-> act_ack);

  a_r7_ack_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_ack) |-> (outst == '0));

  a_r4_grant_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_gnt && !credit_ret && !space_free) |=> (outst == CW'($past(outst) + 1'b1)));

  a_r9_overflow_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> ($past(outst) == '0));

endmodule

bind credit_link_ctrl credit_link_ctrl_chk #(.CREDITS(CREDITS)) chk (
  .clk(clk), .rst_n(rst_n), .act_ack(act_ack), .deact_hint(deact_hint),
  .credit_gnt(credit_gnt), .credit_ret(credit_ret), .space_free(space_free),
  .overflow_err(overflow_err), .outst(outst)
);

// File: tb/credit_link_ctrl_test.sv
module credit_link_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCRED = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_req = 1'b0, reset_pending = 1'b0, space_free = 1'b0, credit_ret = 1'b0;
  logic act_ack, deact_hint, credit_gnt, overflow_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  credit_link_ctrl #(.CREDITS(NCRED)) uut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .reset_pending(reset_pending),
    .space_free(space_free), .credit_ret(credit_ret), .act_ack(act_ack),
    .deact_hint(deact_hint), .credit_gnt(credit_gnt), .overflow_err(overflow_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic activate_and_burst(input string req);
    int n;
    act_req = 1'b1;
    step();
    check({req, " ack low one edge in"}, act_ack, 0);
    step();
    check({req, " ack up after second edge"}, act_ack, 1);
    n = 0;
    for (int i = 0; i < NCRED; i++) begin
      if (i > 0) step();
      n += int'(credit_gnt);
    end
    check({req, " burst grant count"}, n, NCRED);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      n += int'(credit_gnt);
    end
    check("R5 no grant with pool spent", n, 0);
  endtask

  task automatic t_reset();
    check("R1 ack after reset", act_ack, 0);
    check("R1 hint after reset", deact_hint, 0);
    check("R1 grant after reset", credit_gnt, 0);
    check("R1 overflow after reset", overflow_err, 0);
  endtask

  task automatic t_activate();
    activate_and_burst("R2 R3");
    check("R2 ack held", act_ack, 1);
  endtask

  task automatic t_replenish();
    space_free = 1'b1;
    step();
    space_free = 1'b0;
    check("R4 grant after free", credit_gnt, 1);
    step();
    check("R4 single grant per free", credit_gnt, 0);
    space_free = 1'b1;
    step();
    check("R4 back-to-back first", credit_gnt, 1);
    step();
    space_free = 1'b0;
    check("R4 back-to-back second", credit_gnt, 1);
    step();
    check("R4 grants stop", credit_gnt, 0);
  endtask

  task automatic t_hint_drain();
    int g;
    reset_pending = 1'b1;
    step();
    check("R6 hint raised", deact_hint, 1);
    check("R6 no grant under hint", credit_gnt, 0);
    check("R7 ack held while outstanding", act_ack, 1);
    g = 0;
    for (int i = 0; i < NCRED; i++) begin
      credit_ret = 1'b1;
      step();
      g += int'(credit_gnt);
      if (i == NCRED - 2) check("R7 ack high with one left", act_ack, 1);
    end
    credit_ret = 1'b0;
    check("R7 ack low when empty", act_ack, 0);
    check("R6 no grants during drain", g, 0);
    check("R7 hint held while request high", deact_hint, 1);
    act_req = 1'b0;
    step();
    check("R7 hint drops after request low", deact_hint, 0);
    check("R7 ack low when stopped", act_ack, 0);
  endtask

  task automatic t_blocked();
    act_req = 1'b1;
    for (int i = 0; i < 4; i++) step();
    check("R10 no ack while reset pending", act_ack, 0);
    reset_pending = 1'b0;
    activate_and_burst("R10");
  endtask

  task automatic t_req_drop();
    act_req = 1'b0;
    step();
    check("R8 hint on request drop", deact_hint, 1);
    for (int i = 0; i < NCRED / 2; i++) begin
      credit_ret = 1'b1;
      space_free = 1'b1;
      step();
      if (i == NCRED / 2 - 2) check("R8 ack high before paired drain ends", act_ack, 1);
    end
    credit_ret = 1'b0;
    space_free = 1'b0;
    check("R8 ack low after paired drain", act_ack, 0);
    step();
    check("R8 back to stopped", deact_hint, 0);
  endtask

  task automatic t_overflow();
    credit_ret = 1'b1;
    step();
    credit_ret = 1'b0;
    check("R9 overflow pulse", overflow_err, 1);
    step();
    check("R9 overflow single cycle", overflow_err, 0);
    space_free = 1'b1;
    step();
    space_free = 1'b0;
    check("R11 free on empty no overflow", overflow_err, 0);
    activate_and_burst("R9 R11");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_activate();
    t_replenish();
    t_hint_drain();
    t_blocked();
    t_req_drop();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule